// File: doc/BRIEF.md
# Serial Byte/Burst RAM with Three-Wire Access

This block holds 128 bytes of read/write storage behind a three-signal serial port: a transfer-enable level, a serial clock and one bidirectional data line. The data line reaches the block as an input, an output and an output enable. All three serial signals are sampled by the block's own system clock. Edges of the serial clock are detected inside the block, so the serial clock must run well below the system clock.

Every transfer opens with a 24-bit command word. The first command byte carries a burst flag and must otherwise be zero. The second byte picks read or write and must be uniform. The third byte supplies a 7-bit location. A single-byte transfer then moves one location. A burst moves all 128 locations, starting at location 0, whatever address was sent. Dropping the enable line ends a transfer at any point.

Top module: `serial_byte_ram`

## Requirements
- R1: After reset the data output enable is low and every location reads back as 0x00.
- R2: The command word is three bytes, each sent least-significant bit first, each bit taken on a serial-clock rising edge. Byte A has bit 7 as the burst flag (1 = burst) and bits 6..0 zero. Byte B is 0xFF for read or 0x00 for write. Bits 6..0 of byte C select the location. A single-byte write followed by a single-byte read of the same location returns the written value.
- R3: The output enable stays low while the enable line is low and throughout the 24-bit command phase.
- R4: In a read, the output enable rises and bit 0 of the addressed byte appears only after the serial-clock falling edge that ends the 24th command bit. Each later falling edge presents the next bit, LSB first. The output does not change between falling edges.
- R5: If byte A has any of bits 6..0 set, or byte B is neither 0x00 nor 0xFF, the transfer is abandoned. No location changes and the output enable stays low until the enable line drops.
- R6: In burst mode the transfer covers locations 0 through 127 in ascending order and ignores byte C. A burst write followed by a burst read returns all 128 bytes.
- R7: Dropping the enable line partway through a data byte discards the partial byte and leaves that location unchanged.
- R8: A write stores a byte only once its 8th bit has arrived, on that bit's rising edge. In a burst cut short, every completed byte is kept and the unfinished one is not.
- R9: Once a single-byte transfer, or the last byte of a burst, is complete, further serial clocks have no effect. The output enable falls at the falling edge after the final read bit, and extra write bits change no location.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_en | input | 1 | Transfer enable; high opens a transfer, low aborts it |
| ser_clk | input | 1 | Serial clock, sampled by clk |
| sdata_i | input | 1 | Serial data into the block |
| sdata_o | output | 1 | Serial read data out of the block |
| sdata_oe | output | 1 | High while the block drives the data line |

## Verification
The checker assumes that the serial inputs change only between system-clock edges. It also assumes that each serial-clock level is held for several system clocks, so that every rising and falling edge is seen exactly once and data is steady around each rising edge. The stimulus honours this by driving every serial signal on the falling system-clock edge and holding each serial-clock phase for three or more cycles. The enable line is also changed only while the serial clock is low.

// File: rtl/serial_byte_ram_pkg.sv
package serial_byte_ram_pkg;

    localparam int DATA_W   = 8;
    localparam int DEPTH    = 128;
    localparam int AW       = $clog2(DEPTH);
    localparam int BW       = $clog2(DATA_W);
    localparam int CMD_BITS = 3 * DATA_W;
    localparam int CNT_W    = $clog2(CMD_BITS);
    localparam int KEEP     = 2 * DATA_W + AW;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_WR,
        ST_RD_WAIT,
        ST_RD,
        ST_DONE,
        ST_ABORT
    } xfer_state_e;

    typedef struct packed {
        xfer_state_e       state;
        logic [KEEP-1:0]   cmd;
        logic [CNT_W-1:0]  cnt;
        logic [AW-1:0]     addr;
        logic              burst;
        logic [DATA_W-1:0] wbyte;
        logic [BW-1:0]     bitc;
    } ctrl_s;

endpackage

// File: rtl/ser_edge_detect.sv
module ser_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o,
    output logic fall_o
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig_i;
    end

    assign rise_o = sig_i & ~prev_q;
    assign fall_o = ~sig_i & prev_q;
endmodule

// File: rtl/cmd_word_decode.sv
module cmd_word_decode
    import serial_byte_ram_pkg::*;
(
    input  logic [KEEP-1:0] word_i,
    output logic            valid_o,
    output logic            burst_o,
    output logic            read_o,
    output logic [AW-1:0]   addr_o
);
    logic [DATA_W-1:0] mode_byte;
    logic [DATA_W-1:0] dir_byte;
    logic              reserved_clear;
    logic              dir_uniform;

    always_comb begin
        mode_byte      = word_i[DATA_W-1:0];
        dir_byte       = word_i[2*DATA_W-1:DATA_W];
        reserved_clear = (mode_byte[DATA_W-2:0] == '0);
        dir_uniform    = (dir_byte == '0) || (dir_byte == '1);
        valid_o        = reserved_clear && dir_uniform;
        burst_o        = mode_byte[DATA_W-1];
        read_o         = dir_byte[0];
        addr_o         = word_i[KEEP-1:2*DATA_W];
    end
endmodule

// File: rtl/byte_store.sv
module byte_store #(
    parameter int DEPTH_P = 128,
    parameter int WIDTH_P = 8,
    localparam int AW_L   = $clog2(DEPTH_P)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we_i,
    input  logic [AW_L-1:0]    addr_i,
    input  logic [WIDTH_P-1:0] wdata_i,
    output logic [WIDTH_P-1:0] rdata_o
);
    logic [WIDTH_P-1:0] row_q [DEPTH_P];

    for (genvar r = 0; r < DEPTH_P; r++) begin : g_row
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                row_q[r] <= '0;
            else if (we_i && (addr_i == AW_L'(r)))
                row_q[r] <= wdata_i;
        end
    end

    assign rdata_o = row_q[addr_i];
endmodule

// File: rtl/serial_byte_ram.sv
module serial_byte_ram
    import serial_byte_ram_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_en,
    input  logic ser_clk,
    input  logic sdata_i,
    output logic sdata_o,
    output logic sdata_oe
);
    localparam logic [AW-1:0]    LAST_ADDR = AW'(DEPTH - 1);
    localparam logic [CNT_W-1:0] LAST_CMD  = CNT_W'(CMD_BITS - 1);
    localparam logic [BW-1:0]    LAST_BIT  = BW'(DATA_W - 1);

    ctrl_s ctrl_q, ctrl_d;

    logic              sclk_rise, sclk_fall;
    logic [KEEP-1:0]   cmd_word;
    logic              dec_valid, dec_burst, dec_read;
    logic [AW-1:0]     dec_addr;
    logic              mem_we;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata;
    logic [DATA_W-1:0] wbyte_next;

    ser_edge_detect u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (ser_clk),
        .rise_o (sclk_rise),
        .fall_o (sclk_fall)
    );

    // Word as it stands once the current input bit is placed at its slot.
    for (genvar i = 0; i < KEEP; i++) begin : g_word
        assign cmd_word[i] = (ctrl_q.cnt == CNT_W'(i)) ? sdata_i : ctrl_q.cmd[i];
    end

    cmd_word_decode u_dec (
        .word_i  (cmd_word),
        .valid_o (dec_valid),
        .burst_o (dec_burst),
        .read_o  (dec_read),
        .addr_o  (dec_addr)
    );

    byte_store #(
        .DEPTH_P (DEPTH),
        .WIDTH_P (DATA_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (mem_we),
        .addr_i  (ctrl_q.addr),
        .wdata_i (mem_wdata),
        .rdata_o (mem_rdata)
    );

    always_comb begin
        ctrl_d    = ctrl_q;
        mem_we    = 1'b0;
        wbyte_next = ctrl_q.wbyte;
        wbyte_next[ctrl_q.bitc] = sdata_i;
        mem_wdata = wbyte_next;

        if (!xfer_en) begin
            ctrl_d.state = ST_IDLE;
            ctrl_d.cnt   = '0;
            ctrl_d.bitc  = '0;
        end else begin
            unique case (ctrl_q.state)
                ST_IDLE: begin
                    ctrl_d.state = ST_CMD;
                    ctrl_d.cnt   = '0;
                    ctrl_d.cmd   = '0;
                    ctrl_d.bitc  = '0;
                end
                ST_CMD: begin
                    if (sclk_rise) begin
                        ctrl_d.cmd = cmd_word;
                        if (ctrl_q.cnt == LAST_CMD) begin
                            ctrl_d.bitc  = '0;
                            ctrl_d.burst = dec_burst;
                            ctrl_d.addr  = dec_burst ? '0 : dec_addr;
                            if (!dec_valid)    ctrl_d.state = ST_ABORT;
                            else if (dec_read) ctrl_d.state = ST_RD_WAIT;
                            else               ctrl_d.state = ST_WR;
                        end else begin
                            ctrl_d.cnt = ctrl_q.cnt + CNT_W'(1);
                        end
                    end
                end
                ST_WR: begin
                    if (sclk_rise) begin
                        ctrl_d.wbyte = wbyte_next;
                        if (ctrl_q.bitc == LAST_BIT) begin
                            mem_we      = 1'b1;
                            ctrl_d.bitc = '0;
                            if (ctrl_q.burst && ctrl_q.addr != LAST_ADDR)
                                ctrl_d.addr = ctrl_q.addr + AW'(1);
                            else
                                ctrl_d.state = ST_DONE;
                        end else begin
                            ctrl_d.bitc = ctrl_q.bitc + BW'(1);
                        end
                    end
                end
                ST_RD_WAIT: begin
                    if (sclk_fall) begin
                        ctrl_d.state = ST_RD;
                        ctrl_d.bitc  = '0;
                    end
                end
                ST_RD: begin
                    if (sclk_fall) begin
                        if (ctrl_q.bitc == LAST_BIT) begin
                            ctrl_d.bitc = '0;
                            if (ctrl_q.burst && ctrl_q.addr != LAST_ADDR)
                                ctrl_d.addr = ctrl_q.addr + AW'(1);
                            else
                                ctrl_d.state = ST_DONE;
                        end else begin
                            ctrl_d.bitc = ctrl_q.bitc + BW'(1);
                        end
                    end
                end
                ST_DONE, ST_ABORT: ctrl_d = ctrl_q;
                default: ctrl_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q       <= '0;
            ctrl_q.state <= ST_IDLE;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign sdata_oe = (ctrl_q.state == ST_RD);
    assign sdata_o  = sdata_oe & mem_rdata[ctrl_q.bitc];
endmodule

// File: rtl/serial_byte_ram_chk.sv
module serial_byte_ram_chk
    import serial_byte_ram_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        xfer_en,
    input logic        sclk_rise,
    input logic        sclk_fall,
    input logic        sdata_o,
    input logic        sdata_oe,
    input logic        mem_we,
    input logic        burst,
    input logic [AW-1:0] addr,
    input xfer_state_e state
);
    localparam logic [AW-1:0] LAST_A = AW'(DEPTH - 1);

    assert_oe_off_deselected_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_en |=> !sdata_oe);

    assert_oe_off_in_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CMD) |-> !sdata_oe);

    assert_dq_hold_between_falls_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sdata_oe && xfer_en && !sclk_fall) |=> (!sdata_oe || $stable(sdata_o)));

    assert_abort_inert_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ABORT) |-> (!mem_we && !sdata_oe));

    assert_burst_ascends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && burst && addr != LAST_A) |=> (addr == $past(addr) + AW'(1)));

    assert_write_on_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (sclk_rise && xfer_en));

    assert_done_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |-> (!mem_we && !sdata_oe));
endmodule

bind serial_byte_ram serial_byte_ram_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .xfer_en   (xfer_en),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .sdata_o   (sdata_o),
    .sdata_oe  (sdata_oe),
    .mem_we    (mem_we),
    .burst     (ctrl_q.burst),
    .addr      (ctrl_q.addr),
    .state     (ctrl_q.state)
);

// File: tb/serial_byte_ram_tb_top.sv
`timescale 1ns/1ps
module serial_byte_ram_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xfer_en = 1'b0;
    logic ser_clk = 1'b0;
    logic sdata_i = 1'b0;
    logic sdata_o;
    logic sdata_oe;

    int checks = 0;
    int errors = 0;

    logic [7:0] model [128];
    logic       exp_bits [$];
    string      exp_tags [$];
    event       sample_ev;

    always #4 clk = ~clk;

    serial_byte_ram dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .xfer_en  (xfer_en),
        .ser_clk  (ser_clk),
        .sdata_i  (sdata_i),
        .sdata_o  (sdata_o),
        .sdata_oe (sdata_oe)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected read bit per sample request.
    always @(sample_ev) begin
        if (exp_bits.size() == 0) begin
            check("R4 unexpected sample", 1, 0);
        end else begin
            logic  b;
            string t;
            b = exp_bits.pop_front();
            t = exp_tags.pop_front();
            check({t, " oe"}, int'(sdata_oe), 1);
            check({t, " data"}, int'(sdata_o), int'(b));
        end
    end

    task automatic pulse(input logic b);
        @(negedge clk) sdata_i = b;
        @(negedge clk) ser_clk = 1'b1;
        repeat (3) @(negedge clk);
        ser_clk = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic open_xfer();
        @(negedge clk) xfer_en = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic close_xfer();
        @(negedge clk) xfer_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) pulse(v[i]);
    endtask

    task automatic send_cmd(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
        send_byte(a);
        send_byte(b);
        send_byte(c);
    endtask

    task automatic write_byte(input int addr, input logic [7:0] v, input bit extra);
        open_xfer();
        send_cmd(8'h00, 8'h00, 8'(addr));
        send_byte(v);
        if (extra) send_byte(~v);
        close_xfer();
        model[addr] = v;
    endtask

    // Driver: pushes the expected bits, then requests a sample per bit.
    task automatic read_xfer(input bit burst, input int addr, input string tag);
        int n;
        int base;
        n    = burst ? 128 : 1;
        base = burst ? 0 : addr;
        open_xfer();
        send_cmd(burst ? 8'h80 : 8'h00, 8'hFF, 8'(addr));
        for (int k = 0; k < n; k++) begin
            for (int i = 0; i < 8; i++) begin
                exp_bits.push_back(model[base + k][i]);
                exp_tags.push_back(tag);
                ->sample_ev;
                #1;
                pulse(1'b0);
            end
        end
        check("R9 oe low after last bit", int'(sdata_oe), 0);
        close_xfer();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        check("R1 oe after reset", int'(sdata_oe), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 oe idle", int'(sdata_oe), 0);
        read_xfer(1'b0, 5, "R1 reset contents");

        // R2: single-byte writes and reads
        write_byte(3, 8'hA5, 1'b0);
        write_byte(127, 8'h3C, 1'b0);
        write_byte(0, 8'h01, 1'b0);
        read_xfer(1'b0, 3, "R2 loc3");
        read_xfer(1'b0, 127, "R2 loc127");
        read_xfer(1'b0, 0, "R2 loc0");

        // R3/R4: output enable timing around the 24th command bit
        open_xfer();
        check("R3 oe with enable high", int'(sdata_oe), 0);
        send_byte(8'h00);
        send_byte(8'hFF);
        for (int i = 0; i < 7; i++) pulse(logic'((8'd3 >> i) & 1));
        check("R3 oe in command phase", int'(sdata_oe), 0);
        @(negedge clk) sdata_i = 1'b0;
        @(negedge clk) ser_clk = 1'b1;
        repeat (3) @(negedge clk);
        check("R4 oe before falling edge", int'(sdata_oe), 0);
        ser_clk = 1'b0;
        repeat (3) @(negedge clk);
        check("R4 oe after falling edge", int'(sdata_oe), 1);
        check("R4 first bit", int'(sdata_o), int'(model[3][0]));
        pulse(1'b0);
        check("R4 second bit", int'(sdata_o), int'(model[3][1]));
        close_xfer();
        check("R3 oe after enable low", int'(sdata_oe), 0);

        // R5: bad preambles
        open_xfer();
        send_cmd(8'h04, 8'h00, 8'd3);
        send_byte(8'hFF);
        close_xfer();
        open_xfer();
        send_cmd(8'h00, 8'hFE, 8'd3);
        check("R5 mixed direction oe", int'(sdata_oe), 0);
        pulse(1'b0);
        check("R5 mixed direction oe later", int'(sdata_oe), 0);
        close_xfer();
        open_xfer();
        send_cmd(8'h00, 8'h01, 8'd3);
        send_byte(8'h00);
        close_xfer();
        read_xfer(1'b0, 3, "R5 unchanged");

        // R7: partial byte discarded
        open_xfer();
        send_cmd(8'h00, 8'h00, 8'd3);
        for (int i = 0; i < 7; i++) pulse(1'b0);
        close_xfer();
        read_xfer(1'b0, 3, "R7 unchanged");

        // R9: extra write bits after a single-byte write
        write_byte(10, 8'h5A, 1'b1);
        read_xfer(1'b0, 11, "R9 neighbour untouched");
        read_xfer(1'b0, 10, "R9 written");

        // R6: burst write ignores address, then burst read
        open_xfer();
        send_cmd(8'h80, 8'h00, 8'd55);
        for (int k = 0; k < 128; k++) begin
            model[k] = 8'((k * 37 + 11) & 8'hFF);
            send_byte(model[k]);
        end
        close_xfer();
        read_xfer(1'b1, 55, "R6 burst");
        read_xfer(1'b0, 127, "R6 last loc");

        // R8: burst write cut short keeps completed bytes only
        open_xfer();
        send_cmd(8'h80, 8'h00, 8'd9);
        send_byte(8'hEE);
        send_byte(8'hDD);
        for (int i = 0; i < 4; i++) pulse(1'b1);
        close_xfer();
        model[0] = 8'hEE;
        model[1] = 8'hDD;
        read_xfer(1'b1, 0, "R8 cut burst");

        check("R4 scoreboard drained", exp_bits.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule